// File: doc/BRIEF.md
# DRAM Byte-Parity Guard

This block sits beside a local DRAM that a processor and several other bus masters share. On a write it produces one odd-parity bit for each byte lane of the outgoing data. On a read it checks the stored parity bit of each enabled lane against the returned data. A test bit inverts every parity bit that is generated, so software can plant known-bad parity and then exercise the checker.

A two-bit mode selects how errors are reported. Two of the four codes turn checking off. One code checks every read during the access itself, and that access takes one added wait state. The last code treats masters differently. Reads by other masters are checked during the access, with the wait state. Reads by the processor take no wait state; an error is instead held in a sticky latch, and every later processor access raises a bus error.

An access is a one-cycle `acc_req` pulse. The block answers with `ack`, and `bus_err` can only be high during that `ack` cycle. If the access is checked during the access itself, `wait_req` comes one cycle before `ack`.

Top module: `dram_parity_guard`

## Requirements
- R1: After reset, `mode` is 0, the test bit is clear, and the sticky latch is clear. `wait_req`, `ack` and `bus_err` are low until a request arrives.
- R2: `wr_par[i]` is combinational. It is 1 exactly when byte lane i of `acc_wdata` (bits 8i+7..8i) holds an even number of ones, so that the byte and its parity bit together hold an odd count.
- R3: When the test bit (`cfg_inv`, latched by `cfg_we`) is 1, every `wr_par` bit is the complement of its R2 value.
- R4: With mode 0 or mode 2, any access gets `ack` in the cycle after the request. No `wait_req` and no `bus_err` are given.
- R5: With mode 1, a read gets `wait_req` in the cycle after the request and `ack` in the cycle after that. `bus_err` is high with that `ack` exactly when some lane whose `acc_be` bit is 1 has an even count of ones across its data byte and `acc_rpar` bit. Lanes whose `acc_be` bit is 0 are ignored.
- R6: With mode 3, a read by any master other than `CPU_ID` (default 0) is handled exactly as in R5.
- R7: With mode 3, a CPU access gets `ack` in the cycle after the request, with no `wait_req`. A parity error on a CPU read does not raise `bus_err` on that same access; it sets the sticky latch.
- R8: While the sticky latch is set and the mode is 3, every CPU access, read or write, gets `bus_err` together with its `ack`. Accesses by other masters are not affected by the latch.
- R9: Any configuration write (`cfg_we`) clears the sticky latch.
- R10: Writes are never checked. A write gets `ack` in the cycle after the request with no `wait_req`, and `bus_err` only under R8.
- R11: A request presented while `wait_req` is high is ignored. It produces no extra `ack` and does not change the pending result.
- R12: `bus_err` is never high without `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads `cfg_mode` and `cfg_inv` and clears the sticky latch |
| cfg_mode | input | 2 | Check mode, 0 to 3 |
| cfg_inv | input | 1 | Parity inversion test bit |
| acc_req | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_master | input | MASTER_W | Master ID; `CPU_ID` marks the processor |
| acc_be | input | LANES | Byte lanes taking part in the access |
| acc_wdata | input | 8*LANES | Write data |
| acc_rdata | input | 8*LANES | Data read from DRAM |
| acc_rpar | input | LANES | Stored parity read from DRAM |
| wr_par | output | LANES | Parity bits to store with the write data |
| wait_req | output | 1 | One-cycle wait-state request |
| ack | output | 1 | Access complete |
| bus_err | output | 1 | Bus error, valid with `ack` |

## Verification
The assertions check the cycle structure on every cycle. They cover the single-cycle wait followed by `ack`, `bus_err` appearing only with `ack`, and the quiet modes never asking for a wait. They also cover the CPU taking no wait in mode 3, the sticky latch holding until a configuration write, and ignored requests during a wait. Whether `bus_err` carries the right value can only be shown by the bench's sweeps. That depends on the parity of each lane and its byte enable, the mode, the master, and the history of earlier CPU reads. The sweeps go over every error pattern, the byte-enable masks, every mode and master ID, and every byte value for write parity.

// File: rtl/dram_parity_guard.sv
module dram_parity_guard #(
  parameter int LANES    = 4,
  parameter int MASTER_W = 2,
  parameter int CPU_ID   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_inv,
  input  logic                  acc_req,
  input  logic                  acc_write,
  input  logic [MASTER_W-1:0]   acc_master,
  input  logic [LANES-1:0]      acc_be,
  input  logic [8*LANES-1:0]    acc_wdata,
  input  logic [8*LANES-1:0]    acc_rdata,
  input  logic [LANES-1:0]      acc_rpar,
  output logic [LANES-1:0]      wr_par,
  output logic                  wait_req,
  output logic                  ack,
  output logic                  bus_err
);
  logic [1:0]       mode_q;
  logic             inv_q;
  logic             sticky_q;
  logic             err_q;
  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_par[g]   = ~(^acc_wdata[8*g +: 8]) ^ inv_q;
    assign lane_bad[g] = acc_be[g] & ~(^{acc_rdata[8*g +: 8], acc_rpar[g]});
  end

  wire par_err = |lane_bad;
  wire is_cpu  = acc_master == MASTER_W'(CPU_ID);
  wire take    = acc_req & ~wait_req;
  wire chk_now = ~acc_write & mode_q[0] & (~mode_q[1] | ~is_cpu);
  wire defer   = (mode_q == 2'd3) & is_cpu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'd0;
      inv_q    <= 1'b0;
      sticky_q <= 1'b0;
      err_q    <= 1'b0;
      wait_req <= 1'b0;
      ack      <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      wait_req <= 1'b0;
      ack      <= 1'b0;
      bus_err  <= 1'b0;
      if (wait_req) begin
        ack     <= 1'b1;
        bus_err <= err_q;
      end else if (take) begin
        if (chk_now) begin
          wait_req <= 1'b1;
          err_q    <= par_err;
        end else begin
          ack     <= 1'b1;
          bus_err <= defer & sticky_q;
          if (defer & ~acc_write & par_err) sticky_q <= 1'b1;
        end
      end
      if (cfg_we) begin
        mode_q   <= cfg_mode;
        inv_q    <= cfg_inv;
        sticky_q <= 1'b0;
      end
    end
  end
endmodule

module dram_parity_guard_chk #(
  parameter int MASTER_W = 2,
  parameter int CPU_ID   = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                acc_req,
  input logic                acc_write,
  input logic [MASTER_W-1:0] acc_master,
  input logic [1:0]          mode_q,
  input logic                sticky_q,
  input logic                wait_req,
  input logic                ack,
  input logic                bus_err
);
  wire take = acc_req && !wait_req;
  wire cpu  = acc_master == MASTER_W'(CPU_ID);

  AST_BERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> ack); // R12
  AST_WAIT_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n) wait_req |=> (ack && !wait_req)); // R11
  AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n) (take && !mode_q[0]) |=> (ack && !wait_req && !bus_err)); // R4
  AST_CPU_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (take && mode_q == 2'd3 && cpu) |=> (ack && !wait_req)); // R7
  AST_OTHER_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (take && !acc_write && mode_q == 2'd3 && !cpu) |=> (wait_req && !ack)); // R6
  AST_MODE1_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (take && !acc_write && mode_q == 2'd1) |=> (wait_req && !ack)); // R5
  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (take && acc_write) |=> !wait_req); // R10
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (sticky_q && !cfg_we) |=> sticky_q); // R8
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |=> !sticky_q); // R9
endmodule

bind dram_parity_guard dram_parity_guard_chk #(.MASTER_W(MASTER_W), .CPU_ID(CPU_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .acc_req(acc_req), .acc_write(acc_write),
  .acc_master(acc_master), .mode_q(mode_q), .sticky_q(sticky_q),
  .wait_req(wait_req), .ack(ack), .bus_err(bus_err)
);

// File: tb/sim_dram_parity_guard.sv
module sim_dram_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_inv = 1'b0;
  logic        acc_req = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_master = 2'd0;
  logic [3:0]  acc_be = 4'h0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] acc_rdata = 32'h0;
  logic [3:0]  acc_rpar = 4'h0;
  logic [3:0]  wr_par;
  logic        wait_req, ack, bus_err;

  int tests = 0;
  int fails = 0;
  int cur_mode = 0;
  bit sticky = 0;

  always #4 clk = ~clk;

  dram_parity_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
    .acc_req(acc_req), .acc_write(acc_write), .acc_master(acc_master), .acc_be(acc_be),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rpar(acc_rpar),
    .wr_par(wr_par), .wait_req(wait_req), .ack(ack), .bus_err(bus_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(d[8*i +: 8]) % 2) == 0;
    return p;
  endfunction

  task automatic configure(input int m, input logic inv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(m); cfg_inv = inv;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_mode = m;
    sticky = 0;
  endtask

  task automatic access(input logic wr, input int mid, input logic [3:0] be,
                        input logic [3:0] em, input int seed);
    logic [31:0] d;
    logic w1, a1, b1, w2, a2, b2;
    bit err, chk, dfr, eb;
    string tag;
    d = 32'(seed) * 32'h9E3779B1 ^ 32'h5A3C_0F81;
    err = |(em & be);
    chk = !wr && (cur_mode == 1 || (cur_mode == 3 && mid != 0));
    dfr = (cur_mode == 3 && mid == 0);
    eb  = chk ? err : (dfr && sticky);
    if (wr) tag = "R10";
    else if (cur_mode == 0 || cur_mode == 2) tag = "R4";
    else if (cur_mode == 1) tag = "R5";
    else if (mid != 0) tag = "R6";
    else if (sticky) tag = "R8";
    else tag = "R7";
    @(negedge clk);
    acc_req = 1'b1; acc_write = wr; acc_master = 2'(mid); acc_be = be;
    acc_rdata = d; acc_wdata = d; acc_rpar = good_par(d) ^ em;
    @(negedge clk);
    acc_req = 1'b0;
    w1 = wait_req; a1 = ack; b1 = bus_err;
    @(negedge clk);
    w2 = wait_req; a2 = ack; b2 = bus_err;
    if (chk) check(tag, {26'd0, w1, a1, b1, w2, a2, b2}, {26'd0, 3'b100, 2'b01, eb});
    else     check(tag, {26'd0, w1, a1, b1, w2, a2, b2}, {26'd0, 2'b01, eb, 3'b000});
    if (dfr && !wr && err) sticky = 1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] bes [4];
    bes[0] = 4'hF; bes[1] = 4'h5; bes[2] = 4'hA; bes[3] = 4'h0;
    repeat (3) @(negedge clk);
    check("R1", {29'd0, wait_req, ack, bus_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'd0, wait_req, ack, bus_err}, 32'd0);
    acc_wdata = 32'h0;
    #1 check("R1", {28'd0, wr_par}, 32'hF);
    access(1'b0, 0, 4'hF, 4'hF, 1); // R1: mode 0 after reset, bad parity ignored

    // R2 / R3 write parity sweep
    for (int inv = 0; inv < 2; inv++) begin
      configure(0, 1'(inv));
      for (int v = 0; v < 256; v++) begin
        logic [31:0] d;
        logic [3:0] e;
        d = {8'(v), 8'(v) ^ 8'h5A, ~8'(v), 8'(v + 1)};
        @(negedge clk);
        acc_wdata = d;
        e = good_par(d) ^ {4{1'(inv)}};
        #1 check(inv ? "R3" : "R2", {28'd0, wr_par}, {28'd0, e});
      end
    end

    // Mode / master / error / enable sweep (R4 R5 R6 R7 R8 R10)
    for (int m = 0; m < 4; m++) begin
      configure(m, 1'b0);
      for (int mid = 0; mid < 4; mid++) begin
        for (int em = 0; em < 16; em++) begin
          for (int b = 0; b < 4; b++) access(1'b0, mid, bes[b], 4'(em), m * 256 + em * 4 + b);
          access(1'b1, mid, 4'hF, 4'(em), em);
        end
      end
    end

    // R7 / R8 / R9 directed
    configure(3, 1'b0);
    access(1'b0, 0, 4'hF, 4'h2, 7);  // R7: error deferred
    access(1'b0, 0, 4'hF, 4'h0, 8);  // R8: sticky
    access(1'b0, 2, 4'hF, 4'h0, 9);  // R8: other master unaffected
    access(1'b1, 0, 4'hF, 4'h0, 10); // R8: CPU write
    configure(3, 1'b0);              // R9
    access(1'b0, 0, 4'hF, 4'h0, 11);
    check("R9", {31'd0, sticky}, 32'd0);

    // R11: request during wait ignored
    configure(1, 1'b0);
    @(negedge clk);
    acc_req = 1'b1; acc_write = 1'b0; acc_master = 2'd1; acc_be = 4'hF;
    acc_rdata = 32'h1234_5678; acc_rpar = good_par(32'h1234_5678);
    @(negedge clk);
    check("R11", {31'd0, wait_req}, 32'd1);
    acc_rpar = ~good_par(32'h1234_5678);
    @(negedge clk);
    acc_req = 1'b0;
    check("R11", {29'd0, wait_req, ack, bus_err}, 32'b010);
    @(negedge clk);
    check("R11", {29'd0, wait_req, ack, bus_err}, 32'b000);
    @(negedge clk);
    check("R12", {29'd0, wait_req, ack, bus_err}, 32'b000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule